// File: doc/BRIEF.md
# CMI Line Decoder with Code-Violation Flag

The block turns a Coded Mark Inversion line signal back into NRZ data. It samples the line once per half-bit on `clk`, which runs at twice the bit rate, and groups the samples into pairs. It then makes one output bit from each pair. A zero travels as a fixed low-then-high pair. A one travels as a pair at a steady level, and that level alternates from one mark to the next.

The decoder checks both rules of the code. A half-bit pair that is neither a valid zero nor a constant level is reported as a line-code violation. So is a constant-level pair that repeats the level of the previous one. The violation flag is held for the output bit it belongs to.

A select input can take the decoder out of the path. Raw NRZ data then passes straight through at the bit rate. A realign input fixes where the symbol pairs begin. A derived serial clock output falls each time a new bit is presented, so downstream logic can capture the data on its rising edge.

Top module: `cmi_line_decoder`

## Requirements
- R1: With decoding on, a pair whose first half-symbol is 0 and second is 1 yields output bit 0 with no violation.
- R2: With decoding on, a pair of two equal half-symbols (00 or 11) yields output bit 1.
- R3: After reset, the first constant-level pair does not raise a violation. It becomes the reference level.
- R4: A constant-level pair at the same level as the previous constant-level pair raises a violation. Its level then becomes the new reference. A pair at the opposite level raises none.
- R5: A pair of 1 then 0 yields output bit 0 with a violation, and it leaves the reference level unchanged.
- R6: One output bit is produced for every two half-symbols. `bit_stb` is high for exactly one `clk` cycle, in the cycle after the second half-symbol is sampled.
- R7: `nrz_out` and `lcv_out` change only in the cycle in which `bit_stb` is high, and they hold for the whole two-cycle bit period. `ser_clk_out` is 1 while the first half-symbol is taken and 0 when a new bit appears, so the data changes on its falling edge.
- R8: With decoding off (`cmi_en`=0), the output bit equals the first half-symbol of the pair, `lcv_out` stays 0, and the alternation reference is not touched.
- R9: A half-symbol sampled with `realign`=1 is taken as the first half of a new pair, whatever the pair phase was before.
- R10: In reset, `nrz_out`, `lcv_out`, `bit_stb` and `ser_clk_out` are 0, and the alternation reference is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-rate sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cmi_en | input | 1 | 1 = decode CMI, 0 = pass NRZ through |
| realign | input | 1 | Marks the current sample as a first half-symbol |
| sym_in | input | 1 | Line sample, one per half-bit |
| nrz_out | output | 1 | Decoded data bit |
| bit_stb | output | 1 | One-cycle pulse when a new bit is presented |
| lcv_out | output | 1 | Line-code violation for the current bit |
| ser_clk_out | output | 1 | Bit-rate clock; falls as each new bit appears |

## Verification
A wrong alternation reference never shows up on `nrz_out`; it only appears on `lcv_out`. It shows as a missing or spurious violation on the next mark at the wrong level, and a run of zeros can put that mark many bits later. For that reason the sweep covers every ordering of four pair kinds from reset, including marks separated by zeros and by invalid pairs. A wrong pair phase appears within one bit: valid zeros read as high-low pairs and are flagged. The realign and bypass cases are arranged so that a slip in either one shows up in the following two bits.

// File: rtl/cmi_dec_pkg.sv
package cmi_dec_pkg;

    typedef enum logic [1:0] {
        PK_ZERO   = 2'd0,
        PK_MARK   = 2'd1,
        PK_ILLEGAL = 2'd2
    } pair_kind_e;

    typedef struct packed {
        logic bit_val;
        logic lcv;
    } dec_bit_t;

    // Sort a half-symbol pair; zero_first is the first-half level of a zero.
    function automatic pair_kind_e classify(input logic first_h,
                                            input logic second_h,
                                            input logic zero_first);
        if (first_h == second_h)
            return PK_MARK;
        else if (first_h == zero_first)
            return PK_ZERO;
        else
            return PK_ILLEGAL;
    endfunction

endpackage

// File: rtl/cmi_pair_align.sv
module cmi_pair_align (
    input  logic clk,
    input  logic rst,
    input  logic realign,
    input  logic sym_in,
    output logic pair_done,
    output logic first_take,
    output logic first_sym
);
    logic second_phase;

    assign first_take = realign || !second_phase;
    assign pair_done  = second_phase && !realign;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_phase <= 1'b0;
            first_sym    <= 1'b0;
        end else begin
            second_phase <= first_take;
            if (first_take)
                first_sym <= sym_in;
        end
    end
endmodule

// File: rtl/cmi_pair_judge.sv
module cmi_pair_judge
    import cmi_dec_pkg::*;
#(
    parameter logic ZERO_FIRST = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pair_done,
    input  logic     cmi_en,
    input  logic     first_sym,
    input  logic     second_sym,
    output dec_bit_t result
);
    logic       ref_valid;
    logic       ref_lvl;
    pair_kind_e kind;

    assign kind = classify(first_sym, second_sym, ZERO_FIRST);

    always_comb begin
        result = '0;
        if (!cmi_en) begin
            result.bit_val = first_sym;
        end else begin
            unique case (kind)
                PK_ZERO:    result = '{bit_val: 1'b0, lcv: 1'b0};
                PK_MARK:    result = '{bit_val: 1'b1,
                                       lcv: ref_valid && (ref_lvl == second_sym)};
                default:    result = '{bit_val: 1'b0, lcv: 1'b1};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_valid <= 1'b0;
            ref_lvl   <= 1'b0;
        end else if (pair_done && cmi_en && kind == PK_MARK) begin
            ref_valid <= 1'b1;
            ref_lvl   <= second_sym;
        end
    end
endmodule

// File: rtl/cmi_out_stage.sv
module cmi_out_stage
    import cmi_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pair_done,
    input  logic     first_take,
    input  dec_bit_t result,
    output logic     nrz_out,
    output logic     lcv_out,
    output logic     bit_stb,
    output logic     ser_clk_out
);
    dec_bit_t held;

    assign nrz_out = held.bit_val;
    assign lcv_out = held.lcv;

    always_ff @(posedge clk) begin
        if (rst) begin
            held        <= '0;
            bit_stb     <= 1'b0;
            ser_clk_out <= 1'b0;
        end else begin
            bit_stb <= pair_done;
            if (pair_done) begin
                held        <= result;
                ser_clk_out <= 1'b0;
            end else if (first_take) begin
                ser_clk_out <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmi_line_decoder.sv
module cmi_line_decoder
    import cmi_dec_pkg::*;
#(
    parameter logic ZERO_FIRST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cmi_en,
    input  logic realign,
    input  logic sym_in,
    output logic nrz_out,
    output logic bit_stb,
    output logic lcv_out,
    output logic ser_clk_out
);
    logic     pair_done;
    logic     first_take;
    logic     first_sym;
    dec_bit_t result;

    cmi_pair_align u_align (
        .clk        (clk),
        .rst        (rst),
        .realign    (realign),
        .sym_in     (sym_in),
        .pair_done  (pair_done),
        .first_take (first_take),
        .first_sym  (first_sym)
    );

    cmi_pair_judge #(.ZERO_FIRST(ZERO_FIRST)) u_judge (
        .clk        (clk),
        .rst        (rst),
        .pair_done  (pair_done),
        .cmi_en     (cmi_en),
        .first_sym  (first_sym),
        .second_sym (sym_in),
        .result     (result)
    );

    cmi_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .pair_done   (pair_done),
        .first_take  (first_take),
        .result      (result),
        .nrz_out     (nrz_out),
        .lcv_out     (lcv_out),
        .bit_stb     (bit_stb),
        .ser_clk_out (ser_clk_out)
    );
endmodule

// File: rtl/cmi_line_decoder_chk.sv
module cmi_line_decoder_chk (
    input logic clk,
    input logic rst,
    input logic cmi_en,
    input logic realign,
    input logic sym_in,
    input logic nrz_out,
    input logic bit_stb,
    input logic lcv_out,
    input logic ser_clk_out
);
    // R6: strobe is a single-cycle pulse
    p_stb_single_r6: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R7: data and flag hold between strobes
    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |-> ($stable(nrz_out) && $stable(lcv_out)));

    // R7: a new bit coincides with a falling serial clock
    p_clk_falls_r7: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> (!ser_clk_out && $past(ser_clk_out)));

    // R8: no violation in pass-through
    p_no_lcv_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !$past(cmi_en)) |-> !lcv_out);

    // R1: low-high pair is a clean zero
    p_zero_pair_r1: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && $past(cmi_en) && !$past(sym_in, 2) && $past(sym_in))
            |-> (!nrz_out && !lcv_out));

    // R5: high-low pair is a flagged zero
    p_bad_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && $past(cmi_en) && $past(sym_in, 2) && !$past(sym_in))
            |-> (!nrz_out && lcv_out));
endmodule

bind cmi_line_decoder cmi_line_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmi_en      (cmi_en),
    .realign     (realign),
    .sym_in      (sym_in),
    .nrz_out     (nrz_out),
    .bit_stb     (bit_stb),
    .lcv_out     (lcv_out),
    .ser_clk_out (ser_clk_out)
);

// File: tb/cmi_line_decoder_bench.sv
module cmi_line_decoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmi_en = 1'b1;
    logic realign = 1'b0;
    logic sym_in = 1'b0;
    logic nrz_out, bit_stb, lcv_out, ser_clk_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model of the alternation reference and held outputs
    bit m_valid, m_lvl, prev_nrz, prev_lcv;

    always #4 clk = ~clk;

    cmi_line_decoder u_cmi_line_decoder (
        .clk(clk), .rst(rst), .cmi_en(cmi_en), .realign(realign),
        .sym_in(sym_in), .nrz_out(nrz_out), .bit_stb(bit_stb),
        .lcv_out(lcv_out), .ser_clk_out(ser_clk_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; realign = 1'b0; sym_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 nrz", nrz_out, 1'b0);
        check("R10 lcv", lcv_out, 1'b0);
        check("R10 stb", bit_stb, 1'b0);
        check("R10 sclk", ser_clk_out, 1'b0);
        rst = 1'b0;
        m_valid = 0; m_lvl = 0; prev_nrz = 0; prev_lcv = 0;
    endtask

    // called at a negedge; drives one pair and checks both halves
    task automatic send_pair(input logic a, input logic b, input logic ra);
        bit en_nrz, en_lcv;
        sym_in = a; realign = ra;
        @(negedge clk);
        realign = 1'b0;
        check("R6 stb mid", bit_stb, 1'b0);
        check("R7 sclk hi", ser_clk_out, 1'b1);
        check("R7 nrz hold", nrz_out, prev_nrz);
        check("R7 lcv hold", lcv_out, prev_lcv);
        sym_in = b;
        if (!cmi_en) begin
            en_nrz = a; en_lcv = 0;                    // R8
        end else if (a == b) begin
            en_nrz = 1;                                // R2
            en_lcv = m_valid && (m_lvl == b);          // R3 R4
            m_valid = 1; m_lvl = b;
        end else if (a == 1'b0) begin
            en_nrz = 0; en_lcv = 0;                    // R1
        end else begin
            en_nrz = 0; en_lcv = 1;                    // R5
        end
        @(negedge clk);
        check("R6 stb", bit_stb, 1'b1);
        check("R7 sclk lo", ser_clk_out, 1'b0);
        check("R1 R2 R8 nrz", nrz_out, en_nrz);
        check("R3 R4 R5 lcv", lcv_out, en_lcv);
        prev_nrz = en_nrz; prev_lcv = en_lcv;
    endtask

    initial begin
        // exhaustive sweep of four pair kinds over four positions from reset
        for (int seq = 0; seq < 256; seq++) begin
            do_reset();
            for (int i = 0; i < 4; i++) begin
                int k;
                k = (seq >> (2 * i)) & 3;
                case (k)
                    0: send_pair(1'b0, 1'b1, 1'b0);
                    1: send_pair(1'b0, 1'b0, 1'b0);
                    2: send_pair(1'b1, 1'b1, 1'b0);
                    default: send_pair(1'b1, 1'b0, 1'b0);
                endcase
            end
        end

        // R8: pass-through leaves reference untouched
        do_reset();
        send_pair(1'b1, 1'b1, 1'b0);
        cmi_en = 1'b0;
        send_pair(1'b1, 1'b1, 1'b0);
        send_pair(1'b1, 1'b0, 1'b0);
        send_pair(1'b0, 1'b1, 1'b0);
        send_pair(1'b0, 1'b0, 1'b0);
        cmi_en = 1'b1;
        send_pair(1'b0, 1'b0, 1'b0);
        send_pair(1'b0, 1'b0, 1'b0);

        // R9: stray half-symbol, then realign on the next first half
        do_reset();
        sym_in = 1'b1;
        @(negedge clk);
        send_pair(1'b0, 1'b0, 1'b1);
        send_pair(1'b1, 1'b1, 1'b0);
        send_pair(1'b0, 1'b1, 1'b0);
        send_pair(1'b1, 1'b1, 1'b0);
        // R9: realign in mid-stream, one half-symbol early
        sym_in = 1'b0;
        @(negedge clk);
        send_pair(1'b0, 1'b1, 1'b1);
        send_pair(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule